// File: doc/BRIEF.md
# Predicated Instruction Condition Evaluator

This block decides whether the instruction now in decode is allowed to execute. Each instruction carries a four-bit predicate field in its top bits. The three upper bits of that field pick one of eight base conditions, which are formed from the four status flags: negative, zero, carry and overflow. The lowest bit of the field asks for the chosen condition to be inverted. Pipeline control reads the single enable output and either commits the instruction or turns it into a bubble.

The block also takes two blocking inputs: a pending interrupt and an undefined-instruction indication. Either one forces the enable low, whatever the predicate evaluates to. The base conditions pass through an active-low 3-to-8 select decoder and a one-hot multiplexer, and then through an optional inversion. A parameter chooses whether the enable comes straight out of the combinational logic or passes through one register first, so that it lines up with a pipeline stage.

Top module: `pred_eval`

## Requirements
- R1: The predicate field is `instr_i[31:28]`. When the result is not blocked, `exec_en_o` is 1 exactly when the selected base condition XOR bit 28 is 1.
- R2: Field bits 31:29 select the base condition, listed here by select value from 0 to 7: Z, C, N, V, (C and not Z), (N == V), (not Z and N == V), and constant 1.
- R3: Select 7 with bit 28 = 0 (field 4'b1110) always enables. Field 4'b1111 never enables, whatever the flag values are.
- R4: The internal select lines are active low, and exactly one of them is low at any time. The low line's index equals bits 31:29.
- R5: When `irq_pend_i` or `undef_i` is 1, `exec_en_o` is 0 for every field and flag value.
- R6: With `REG_OUT = 0`, the output follows the inputs in the same cycle. With `REG_OUT = 1`, the output shows the inputs of the previous rising edge, and it is 0 during reset and in the first cycle after reset.
- R7: Instruction bits 27:0 have no effect on `exec_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used only when REG_OUT = 1 |
| rst_ni | input | 1 | Active-low synchronous reset of the output register |
| instr_i | input | 32 | Instruction word; bits 31:28 hold the predicate |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| irq_pend_i | input | 1 | Pending interrupt, blocks execution |
| undef_i | input | 1 | Undefined instruction, blocks execution |
| exec_en_o | output | 1 | Execute enable |

## Verification
The bench sweeps all 16 predicate values against all 16 flag combinations and all four blocking combinations, and checks each one against a model written as a plain case statement. It pays most attention to the compound conditions. If greater-than were built from the wrong signed relation, or unsigned-higher from the wrong carry polarity, the failure would appear only on a few flag patterns, and the full sweep catches those. A design that applied the blocking inputs before the inversion stage would enable instructions on blocked never-type predicates, and the bench checks for exactly that. It also writes random values into the low 28 instruction bits to show they are ignored, and it checks the one-cycle delay of the registered variant.

// File: rtl/pred_eval_pkg.sv
package pred_eval_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned N_COND = 1 << SEL_W;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Base condition vector, index = select value
  function automatic logic [N_COND-1:0] base_conds(input flags_t f);
    logic [N_COND-1:0] b;
    b[0] = f.z;
    b[1] = f.c;
    b[2] = f.n;
    b[3] = f.v;
    b[4] = f.c & ~f.z;
    b[5] = ~(f.n ^ f.v);
    b[6] = ~f.z & ~(f.n ^ f.v);
    b[7] = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/pred_sel_dec.sv
module pred_sel_dec
  import pred_eval_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  output logic [N_COND-1:0] sel_n_o
);
  for (genvar g = 0; g < N_COND; g++) begin : g_line
    assign sel_n_o[g] = ~(sel_i == SEL_W'(g));
  end

  always_comb begin
    p_onehot_low_r4: assert ($countones(~sel_n_o) == 1);
  end
endmodule

// File: rtl/pred_mux.sv
module pred_mux
  import pred_eval_pkg::*;
(
  input  logic [N_COND-1:0] cond_i,
  input  logic [N_COND-1:0] sel_n_i,
  output logic              out_o
);
  logic [N_COND-1:0] pass;
  for (genvar g = 0; g < N_COND; g++) begin : g_sw
    assign pass[g] = cond_i[g] & ~sel_n_i[g];
  end
  assign out_o = |pass;
endmodule

// File: rtl/pred_eval.sv
module pred_eval
  import pred_eval_pkg::*;
#(
  parameter bit REG_OUT = 1'b0,
  parameter int unsigned INSTR_W = 32,
  localparam int unsigned FLD_LO = INSTR_W - 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               flag_n_i,
  input  logic               flag_z_i,
  input  logic               flag_c_i,
  input  logic               flag_v_i,
  input  logic               irq_pend_i,
  input  logic               undef_i,
  output logic               exec_en_o
);
  flags_t            flags;
  logic [N_COND-1:0] conds;
  logic [N_COND-1:0] sel_n;
  logic [SEL_W-1:0]  sel;
  logic              invert;
  logic              chosen;
  logic              cond_ok;
  logic              blocked;
  logic              en_comb;

  assign flags   = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};
  assign conds   = base_conds(flags);
  assign sel     = instr_i[INSTR_W-1 -: SEL_W];
  assign invert  = instr_i[FLD_LO];
  assign blocked = irq_pend_i | undef_i;

  pred_sel_dec u_dec (.sel_i(sel), .sel_n_o(sel_n));
  pred_mux     u_mux (.cond_i(conds), .sel_n_i(sel_n), .out_o(chosen));

  assign cond_ok = chosen ^ invert;
  assign en_comb = cond_ok & ~blocked;

  if (REG_OUT) begin : g_reg
    logic en_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= en_comb;
    end
    assign exec_en_o = en_q;

    p_reg_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(blocked) |-> !exec_en_o);
    p_reg_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> exec_en_o == $past(cond_ok & ~blocked));
  end else begin : g_comb
    assign exec_en_o = en_comb;
  end

  always_comb begin
    if (blocked) p_block_r5: assert (!en_comb);
    if (instr_i[INSTR_W-1 -: 4] == 4'b1111) p_never_r3: assert (!cond_ok);
    if (instr_i[INSTR_W-1 -: 4] == 4'b1110) p_always_r3: assert (cond_ok);
    p_sel_match_r4: assert (!sel_n[sel]);
  end
endmodule

// File: tb/pred_eval_tb_top.sv
module pred_eval_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic fn = 0, fz = 0, fc = 0, fv = 0, irq = 0, und = 0;
  logic en_c, en_r;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pred_eval #(.REG_OUT(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .flag_n_i(fn), .flag_z_i(fz),
    .flag_c_i(fc), .flag_v_i(fv), .irq_pend_i(irq), .undef_i(und), .exec_en_o(en_c));
  pred_eval #(.REG_OUT(1'b1)) dut_r (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .flag_n_i(fn), .flag_z_i(fz),
    .flag_c_i(fc), .flag_v_i(fv), .irq_pend_i(irq), .undef_i(und), .exec_en_o(en_r));

  function automatic bit model(input logic [3:0] f, input bit n, z, c, v, i, u);
    bit r;
    case (f)
      4'h0: r = z;              4'h1: r = !z;
      4'h2: r = c;              4'h3: r = !c;
      4'h4: r = n;              4'h5: r = !n;
      4'h6: r = v;              4'h7: r = !v;
      4'h8: r = c && !z;        4'h9: r = !c || z;
      4'hA: r = n == v;         4'hB: r = n != v;
      4'hC: r = !z && n == v;   4'hD: r = z || n != v;
      4'hE: r = 1;              default: r = 0;
    endcase
    return r && !i && !u;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: field=%h flags=%b%b%b%b irq=%b und=%b act=%b exp=%b",
               req, instr[31:28], fn, fz, fc, fv, irq, und, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit prev;
    repeat (2) @(posedge clk);
    #2 chk("R6 reset", en_r, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2 chk("R6 first cycle", en_r, 1'b0);
    // exhaustive sweep: R1 R2 R3 R5, registered path R6, random low bits R7
    for (int b = 0; b < 4; b++) begin
      for (int f = 0; f < 16; f++) begin
        for (int fl = 0; fl < 16; fl++) begin
          @(negedge clk);
          instr = {f[3:0], 28'($urandom)};
          {fn, fz, fc, fv} = fl[3:0];
          {irq, und} = b[1:0];
          prev = model(f[3:0], fn, fz, fc, fv, irq, und);
          #1;
          chk(b != 0 ? "R5" : (f >= 14 ? "R3" : "R1/R2"), en_c, prev);
          @(posedge clk); #2;
          chk("R6 registered", en_r, prev);
        end
      end
    end
    // R7: vary low bits only, output must hold
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      instr = {4'h8, 28'($urandom)};
      {fn, fz, fc, fv, irq, und} = 6'b001000;
      #1 chk("R7", en_c, 1'b1);
      instr[27:0] = 28'($urandom);
      #1 chk("R7", en_c, 1'b1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule